// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked system to an external asynchronous static RAM of 65,536 words by 16 bits. On the user side there is a single request port. A request carries a read/write flag, a word address, write data and a two-bit byte mask. The controller accepts the request, runs one complete memory access, and returns a one-cycle acknowledge. For a read, the acknowledge comes with the returned word.

On the memory side the controller drives the address and two chip selects of opposite polarity (one active low, one active high). It also drives an active-low write strobe, an active-low output enable, and separate active-low selects for the lower and upper byte. The data bus is split into an output word, a driver enable and an input word, so that the pad ring can form the bidirectional pins.

Every access runs through four phases: idle, setup, active and recovery. The length of each phase is a whole number of clock cycles. That number is derived from the clock period and the memory's nanosecond timing minimums, using ceiling division with a floor of one cycle. All of these values are parameters.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `reqReady` is high, the memory pins are idle: `memCs1N`=1, `memCs2`=0, `memWeN`=1, `memOeN`=1, `memLbN`=`memUbN`=1 and `memDqOe`=0. `ackValid` is 0 in those cycles.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` then stays low until the access has fully recovered. Request fields presented while `reqReady` is low have no effect.
- R3: `reqMask[0]` enables the lower byte (data bits 7:0, `memLbN`) and `reqMask[1]` enables the upper byte (bits 15:8, `memUbN`). A 1 means enabled. A write leaves each disabled byte of the addressed word unchanged.
- R4: A read returns the enabled bytes in `ackRdata` and zero in the disabled byte lanes. With mask 00 both byte selects stay high, so the memory is never selected: a write changes nothing and a read returns 0.
- R5: Each accepted request gives exactly one single-cycle `ackValid` pulse. With the default timing and a 20 ns clock, the pulse is high in the cycle after the third edge that follows acceptance, and `reqReady` returns one cycle after the pulse.
- R6: Each phase length is the ceiling of a nanosecond minimum divided by the clock period, and never less than one cycle.
- R7: During a write, the write strobe stays low for at least 40 ns. Write data is driven at least 25 ns before the strobe rises. Address and chip selects are valid at least 45 ns before it rises. Successive writes start at least 55 ns apart.
- R8: While the write strobe is low, address and byte selects do not change, and every write is ended by the write strobe rising.
- R9: Read data is captured no earlier than 55 ns after the address and chip selects became valid and 25 ns after the output enable fell.
- R10: The controller's data driver is on only while the output enable is high. It turns on no sooner than 20 ns after the output enable rose, and stays on for the cycle after the write strobe rises.
- R11: The two chip selects always change together, and a byte select is low only while both chip selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte enables: bit 0 lower, bit 1 upper |
| ackValid | output | 1 | One-cycle completion pulse |
| ackRdata | output | 16 | Read data, valid with ackValid after a read |
| memAddr | output | 16 | Memory address |
| memCs1N | output | 1 | Chip select, active low |
| memCs2 | output | 1 | Chip select, active high |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower byte select, active low |
| memUbN | output | 1 | Upper byte select, active low |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 1 | Enable of the controller's data driver |
| memDqIn | input | 16 | Data returned by the memory |

## Verification
Two things can fall in the same cycle. The first is the acknowledge and recovery of one access. The second is a new request that has been waiting since that access was accepted. The bench holds each new request on the port while the previous access is still running. Its per-cycle model then judges that acceptance happens only in the first ready cycle and that the old access still completes with its own data. The same timing places a write directly behind a read, so the controller's driver turn-on meets the memory's output release. A timed memory model in the bench judges that handover as ownership of the bus, and it also checks every write and read timing minimum.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOVER
  } phase_t;

  // Pin intent for the cycle that follows the current clock edge.
  typedef struct packed {
    logic load;     // latch the request fields
    logic selOn;    // chip selects (and enabled byte selects) active
    logic weOn;     // write strobe low
    logic oeOn;     // output enable low
    logic dqOn;     // own data driver on
    logic capture;  // sample read data at this edge
    logic ack;      // pulse acknowledge next cycle
  } ctlStrb_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
  import asram_pkg::*;
#(
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 25,
  parameter int unsigned T_HZOE_NS = 20,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_PWE_NS  = 40,
  parameter int unsigned T_AW_NS   = 45,
  parameter int unsigned T_SD_NS   = 25
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output ctlStrb_t strb
);

  // R6: phase lengths in whole cycles
  localparam int unsigned RD_ACT = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)),
                                        ns2cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned RD_REC = ns2cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned AW_CYC = ns2cyc(T_AW_NS, CLK_NS);
  // setup phase already contributes one cycle of address/select lead
  localparam int unsigned WR_ACT = umax(umax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                        (AW_CYC > 1) ? AW_CYC - 1 : 1);
  localparam int unsigned WC_CYC = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WR_REC = (WC_CYC > WR_ACT + 2) ? WC_CYC - WR_ACT - 1 : 1;
  localparam int unsigned MAXC   = umax(umax(RD_ACT, RD_REC), umax(WR_ACT, WR_REC));
  localparam int unsigned CNT_W  = $clog2(MAXC + 1);

  phase_t           phase, phaseNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             isWrite;
  logic             wrCur;

  assign wrCur    = (phase == PH_IDLE) ? reqWrite : isWrite;
  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    phaseNxt     = phase;
    cntNxt       = cnt;
    strb         = '0;
    case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          if (reqWrite) begin
            phaseNxt = PH_SETUP;
          end else begin
            phaseNxt = PH_ACTIVE;
            cntNxt   = CNT_W'(RD_ACT - 1);
          end
        end
      end
      PH_SETUP: begin
        phaseNxt = PH_ACTIVE;
        cntNxt   = CNT_W'(WR_ACT - 1);
      end
      PH_ACTIVE: begin
        if (cnt == '0) begin
          phaseNxt     = PH_RECOVER;
          cntNxt       = isWrite ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
          strb.ack     = 1'b1;
          strb.capture = !isWrite;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      PH_RECOVER: begin
        if (cnt == '0) phaseNxt = PH_IDLE;
        else           cntNxt   = cnt - 1'b1;
      end
      default: phaseNxt = PH_IDLE;
    endcase

    strb.selOn = (phaseNxt == PH_SETUP) || (phaseNxt == PH_ACTIVE) ||
                 (phaseNxt == PH_RECOVER && phase == PH_ACTIVE && wrCur);
    strb.weOn  = (phaseNxt == PH_ACTIVE) && wrCur;
    strb.oeOn  = (phaseNxt == PH_ACTIVE) && !wrCur;
    strb.dqOn  = wrCur && ((phaseNxt == PH_SETUP) || (phaseNxt == PH_ACTIVE) ||
                           (phaseNxt == PH_RECOVER && phase == PH_ACTIVE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
      if (strb.load) isWrite <= reqWrite;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

endmodule

// File: rtl/asram_dp.sv
`timescale 1ns/1ps
module asram_dp
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [1:0]        maskQ;
  logic [1:0]        maskUse;
  logic [DATA_W-1:0] laneData;

  assign maskUse = strb.load ? reqMask : maskQ;

  // disabled byte lanes read back as zero
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign laneData[g*HALF_W +: HALF_W] = maskQ[g] ? memDqIn[g*HALF_W +: HALF_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      memAddr  <= '0;
      memDqOut <= '0;
      memCs1N  <= 1'b1;
      memCs2   <= 1'b0;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memLbN   <= 1'b1;
      memUbN   <= 1'b1;
      memDqOe  <= 1'b0;
      ackValid <= 1'b0;
      ackRdata <= '0;
    end else begin
      if (strb.load) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
        maskQ    <= reqMask;
      end
      memCs1N  <= !strb.selOn;
      memCs2   <= strb.selOn;
      memLbN   <= !(strb.selOn && maskUse[0]);
      memUbN   <= !(strb.selOn && maskUse[1]);
      memWeN   <= !strb.weOn;
      memOeN   <= !strb.oeOn;
      memDqOe  <= strb.dqOn;
      ackValid <= strb.ack;
      if (strb.capture) ackRdata <= laneData;
    end
  end

  // R10
  no_fight_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

  // R10
  we_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe && memOeN));

  // R10
  turn_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> $past(memOeN));

  // R8
  hold_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memLbN) && $stable(memUbN)));

  // R11
  byte_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memLbN || !memUbN) |-> (!memCs1N && memCs2));

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 25,
  parameter int unsigned T_HZOE_NS = 20,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_PWE_NS  = 40,
  parameter int unsigned T_AW_NS   = 45,
  parameter int unsigned T_SD_NS   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  ctlStrb_t strb;

  asram_ctl #(
    .CLK_NS   (CLK_NS),
    .T_RC_NS  (T_RC_NS),
    .T_AA_NS  (T_AA_NS),
    .T_DOE_NS (T_DOE_NS),
    .T_HZOE_NS(T_HZOE_NS),
    .T_WC_NS  (T_WC_NS),
    .T_PWE_NS (T_PWE_NS),
    .T_AW_NS  (T_AW_NS),
    .T_SD_NS  (T_SD_NS)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDqIn (memDqIn),
    .ackValid(ackValid),
    .ackRdata(ackRdata),
    .memAddr (memAddr),
    .memCs1N (memCs1N),
    .memCs2  (memCs2),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memLbN  (memLbN),
    .memUbN  (memUbN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe)
  );

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam real T_AA   = 55.0;
  localparam real T_DOE  = 25.0;
  localparam real T_PWE  = 40.0;
  localparam real T_AW   = 45.0;
  localparam real T_SD   = 25.0;
  localparam real T_WC   = 55.0;
  localparam real T_HZOE = 20.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, ackValid;
  logic [15:0] ackRdata, memAddr, memDqOut;
  logic        memCs1N, memCs2, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqIn = 16'hC3C3;

  always #10 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .ackValid(ackValid), .ackRdata(ackRdata), .memAddr(memAddr), .memCs1N(memCs1N),
    .memCs2(memCs2), .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- timed memory model ----------------
  logic [15:0] memArr [logic [15:0]];
  real  tAddr = -1000.0, tDq = -1000.0, tCs = -1000.0, tWeFall = -1000.0;
  real  tOeFall = -1000.0, tOeRise = -1000.0, tWrStart = -1000.0;
  bit   haveWr = 0;
  logic pWr = 0, pWeN = 1, pOeN = 1, pCsAct = 0, pDqOe = 0, pLbN = 1, pUbN = 1;
  logic [15:0] pAddr = '0, pDq = '0;

  task automatic modelStep();
    real         now;
    logic        csAct, sel, wr, drv, valid;
    logic [15:0] st;
    logic [7:0]  lo, hi;
    now   = $realtime;
    csAct = !memCs1N && memCs2;
    sel   = csAct && (!memLbN || !memUbN);
    wr    = sel && !memWeN;
    if (rstN) begin
      if (memAddr != pAddr) begin
        chk(!pWr, "R8", "address moved while writing", memAddr, pAddr);
        tAddr = now;
      end
      if (pWr && wr && (memLbN != pLbN || memUbN != pUbN))
        chk(1'b0, "R8", "byte select moved while writing", {memUbN, memLbN}, {pUbN, pLbN});
      if (memDqOut != pDq || memDqOe != pDqOe) tDq = now;
      if (csAct && !pCsAct) tCs = now;
      if (!memWeN && pWeN) tWeFall = now;
      if (!memOeN && pOeN) tOeFall = now;
      if (memOeN && !pOeN) tOeRise = now;
      if (memDqOe && !pDqOe)
        chk(memOeN && (now - tOeRise >= T_HZOE), "R10", "driver turn-on after OE release ns",
            longint'(now - tOeRise), longint'(T_HZOE));
      if (pWr && !wr) begin
        chk(now - tWeFall >= T_PWE, "R7", "write pulse ns", longint'(now - tWeFall), longint'(T_PWE));
        chk(pDqOe && (now - tDq >= T_SD), "R7", "data setup ns", longint'(now - tDq), longint'(T_SD));
        chk(now - tAddr >= T_AW, "R7", "address setup ns", longint'(now - tAddr), longint'(T_AW));
        chk(now - tCs >= T_AW, "R7", "select setup ns", longint'(now - tCs), longint'(T_AW));
        chk(memWeN == 1'b1, "R8", "write ended by strobe rising", memWeN, 1);
        chk(memDqOe == 1'b1, "R10", "driver held after strobe rise", memDqOe, 1);
        st = memArr.exists(pAddr) ? memArr[pAddr] : 16'h0000;
        if (!pLbN) st[7:0]  = pDq[7:0];
        if (!pUbN) st[15:8] = pDq[15:8];
        memArr[pAddr] = st;
      end
      if (wr && !pWr) begin
        if (haveWr)
          chk(now - tWrStart >= T_WC, "R7", "write cycle ns", longint'(now - tWrStart), longint'(T_WC));
        tWrStart = now;
        haveWr   = 1;
      end
    end
    drv = sel && !memOeN && memWeN;
    if (rstN && drv && memDqOe) chk(1'b0, "R10", "bus contention", memDqOe, 0);
    valid = (now - tAddr >= T_AA) && (now - tCs >= T_AA) && (now - tOeFall >= T_DOE);
    st = memArr.exists(memAddr) ? memArr[memAddr] : 16'h0000;
    lo = !memLbN ? (valid ? st[7:0]  : ~st[7:0])  : 8'hA5;
    hi = !memUbN ? (valid ? st[15:8] : ~st[15:8]) : 8'h5A;
    memDqIn = drv ? {hi, lo} : 16'hC3C3;
    pWr = wr; pWeN = memWeN; pOeN = memOeN; pCsAct = csAct; pDqOe = memDqOe;
    pLbN = memLbN; pUbN = memUbN; pAddr = memAddr; pDq = memDqOut;
  endtask

  initial begin
    #0.5;
    forever begin
      modelStep();
      #1;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [15:0] shadow [logic [15:0]];
  int          left = 0;
  bit          acceptFlag = 0;
  bit          expWr = 0;
  logic [15:0] expRd = '0;
  int          cycles = 0;

  task automatic finishUp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    logic [15:0] sh;
    cycles++;
    if (!rstN) begin
      left = 0;
      acceptFlag = 0;
    end else begin
      acceptFlag = 0;
      if (left > 0) left--;
      else if (reqValid) begin
        left = 4;  // R5 R6: default ceilings give ack after the third edge, ready after the fourth
        acceptFlag = 1;
        expWr = reqWrite;
        sh = shadow.exists(reqAddr) ? shadow[reqAddr] : 16'h0000;
        if (reqWrite) begin
          if (reqMask[0]) sh[7:0]  = reqWdata[7:0];
          if (reqMask[1]) sh[15:8] = reqWdata[15:8];
          shadow[reqAddr] = sh;
        end else begin
          expRd = {reqMask[1] ? sh[15:8] : 8'h00, reqMask[0] ? sh[7:0] : 8'h00};
        end
      end
    end
    if (cycles > 20000) begin
      chk(1'b0, "watchdog", "run did not end", cycles, 20000);
      finishUp();
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(reqReady == (left == 0), "R2", "ready", reqReady, left == 0);
      chk(ackValid == (left == 1), "R5", "ack pulse", ackValid, left == 1);
      if (left == 1 && !expWr)
        chk(ackRdata == expRd, "R3 R4", "read data", ackRdata, expRd);
      chk(memCs1N == !memCs2, "R11", "chip selects paired", {memCs1N, memCs2}, {!memCs2, memCs2});
      chk((memLbN && memUbN) || (!memCs1N && memCs2), "R11", "byte select without chip select",
          {memLbN, memUbN}, 2'b11);
      if (left == 0)
        chk(memCs1N && !memCs2 && memWeN && memOeN && memLbN && memUbN && !memDqOe && !ackValid,
            "R1", "idle pins", {memCs1N, memCs2, memWeN, memOeN, memLbN, memUbN, memDqOe},
            7'b1011110);
    end
  end

  task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqMask = m;
    do @(negedge clk); while (!acceptFlag);
    reqValid = 1'b0;
    reqAddr  = ~a;   // R2: changes while busy must not matter
    reqWdata = ~d;
    reqMask  = ~m;
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(memCs1N && !memCs2 && memWeN && memOeN && memLbN && memUbN && !memDqOe,
        "R1", "reset pins", {memCs1N, memCs2, memWeN, memOeN, memLbN, memUbN, memDqOe}, 7'b1011110);
    chk(reqReady && !ackValid, "R1", "reset handshake", {reqReady, ackValid}, 2'b10);

    issue(1, 16'h0000, 16'h1234, 2'b11);
    issue(0, 16'h0000, 16'h0000, 2'b11);   // R9 read after write
    issue(1, 16'hFFFF, 16'hBEEF, 2'b11);   // top address
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    issue(1, 16'h0010, 16'hAAAA, 2'b11);
    issue(1, 16'h0010, 16'h5555, 2'b01);   // R3 lower only
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(1, 16'h0010, 16'h1122, 2'b10);   // R3 upper only
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(0, 16'h0010, 16'h0000, 2'b01);   // R4 lane zeroing
    issue(0, 16'h0010, 16'h0000, 2'b10);
    issue(1, 16'h0010, 16'hFFFF, 2'b00);   // R4 no byte enabled
    issue(0, 16'h0010, 16'h0000, 2'b11);
    issue(0, 16'h0010, 16'h0000, 2'b00);
    issue(0, 16'h7777, 16'h0000, 2'b11);   // never written
    repeat (3) @(negedge clk);

    lf = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue(lf[5], lf[15] ? {12'hFFF, lf[3:0]} : {12'h000, lf[3:0]}, lf ^ 16'h3C5A, lf[7:6]);
      if (lf[8]) repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    finishUp();
  end

endmodule